// File: doc/BRIEF.md
# Receive Character Queue with Overrun Holding Stage

This block buffers received characters between a serial receiver and a CPU read port. Each completed character arrives with three status bits: break, framing error and parity error. The block stores it in a first-in first-out queue of `DEPTH` positions, and each position keeps the status bits beside the data byte. The CPU pulls the oldest position with a one-cycle read strobe. The data and status of that position are visible at the read port in the same cycle as the strobe.

When the queue is full, one more character can wait in a holding stage, which stands in for the receiver's shift register. A CPU read frees a slot, and the waiting character moves into the queue in that same cycle, so the full flag stays set. If another character completes while the queue is full and the holding stage is occupied, the waiting character is dropped, the new one takes its place, and a sticky overrun flag is raised. Only an explicit clear-error command resets that flag.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds up to `DEPTH` characters. Each entry is `DW` data bits plus break, framing and parity bits, and entries are read back in arrival order with their own status bits unchanged.
- R2: `rx_ready` is 1 in the cycle after a character enters the queue. It stays 1 while at least one entry remains, and it goes to 0 in the cycle after a read that removes the last entry.
- R3: `fifo_full` goes to 1 in the cycle after a transfer brings the queue to `DEPTH` occupied entries.
- R4: When a read removes an entry while a character waits in the holding stage, that character enters the queue in the same clock edge, and `fifo_full` stays 1.
- R5: `overrun` goes to 1 in the cycle after a character arrives while the queue is full, the holding stage is occupied and no read takes place.
- R6: On overrun the character that was waiting, with its status bits, is discarded and replaced by the new arrival, which is the next one to enter the queue.
- R7: `overrun` is sticky: it returns to 0 only in the cycle after `clr_err` is pulsed. If an overrun event and `clr_err` fall in the same cycle, the flag is left at 1.
- R8: While the queue is not empty, `rd_data`, `rd_brk`, `rd_fe` and `rd_pe` show the oldest entry combinationally, so the value present during the read strobe is the one removed.
- R9: A read strobe on an empty queue removes nothing and changes no flag. The read outputs then show the most recently removed entry.
- R10: When a read and an arriving character coincide with a full queue, the read frees a slot first. The character is kept, either in the queue or, if a character was already waiting, in the holding stage, and no overrun occurs.
- R11: After reset the queue and the holding stage are empty, `rx_ready`, `fifo_full` and `overrun` are 0, and all read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a character has completed |
| rx_data | input | DW | Data of the completed character |
| rx_brk | input | 1 | Break status of the completed character |
| rx_fe | input | 1 | Framing-error status of the completed character |
| rx_pe | input | 1 | Parity-error status of the completed character |
| rd_stb | input | 1 | CPU read strobe, removes the oldest entry |
| clr_err | input | 1 | Command that clears the overrun flag |
| rd_data | output | DW | Data of the oldest entry, or of the last removed entry when empty |
| rd_brk | output | 1 | Break status matching `rd_data` |
| rd_fe | output | 1 | Framing status matching `rd_data` |
| rd_pe | output | 1 | Parity status matching `rd_data` |
| rx_ready | output | 1 | Queue holds at least one entry |
| fifo_full | output | 1 | All `DEPTH` entries are occupied |
| overrun | output | 1 | Sticky flag: a waiting character was lost |

## Verification
The bench builds the block with `DEPTH` = 4 and `DW` = 8. With this shallow queue the full, holding and overrun states are reached within a handful of arrivals. A few thousand cycles therefore pass through every fill level many times and hit every combination of arrival, read and clear at each level. Arrivals carry an incrementing byte with derived status bits, so a dropped or reordered character appears directly at the read port. A depth of 4 is also a power of two, which selects the natural-wrap pointer variant.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

   // status bits that travel with every stored character
   typedef struct packed {
      logic brk;
      logic fe;
      logic pe;
   } rcq_stat_t;

   localparam int RCQ_STAT_W = $bits(rcq_stat_t);

endpackage

// File: rtl/rcq_mem.sv
module rcq_mem #(
   parameter int DEPTH = 8,
   parameter int EW    = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [EW-1:0] wr_word,
   input  logic          rd_en,
   output logic [EW-1:0] head_word
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW-1:0] wr_nxt, rd_nxt;
   logic [EW-1:0] slot [DEPTH];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             slot[i] <= '0;
            else if (wr_en && wr_ptr == PW'(i))     slot[i] <= wr_word;
         end
      end
   endgenerate

   assign head_word = slot[rd_ptr];

endmodule

// File: rtl/rcq_ctrl.sv
module rcq_ctrl #(
   parameter int DEPTH = 8,
   parameter int EW    = 11,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_valid,
   input  logic [EW-1:0] char_word,
   input  logic          rd_stb,
   input  logic          clr_err,
   output logic          pop,
   output logic          push,
   output logic [EW-1:0] push_word,
   output logic [CW-1:0] count,
   output logic          hold_v,
   output logic          ovr
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [EW-1:0] hold_w;
   logic          room;
   logic          hold_load, hold_clear, ovr_set;

   assign pop  = rd_stb && (count != '0);
   assign room = pop || (count != FULL_CNT);

   always_comb begin
      push       = 1'b0;
      push_word  = char_word;
      hold_load  = 1'b0;
      hold_clear = 1'b0;
      ovr_set    = 1'b0;
      if (hold_v) begin
         if (pop) begin
            push      = 1'b1;
            push_word = hold_w;
            if (char_valid) hold_load  = 1'b1;
            else            hold_clear = 1'b1;
         end else if (char_valid) begin
            hold_load = 1'b1;
            ovr_set   = 1'b1;
         end
      end else if (char_valid) begin
         if (room) push      = 1'b1;
         else      hold_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         hold_v <= 1'b0;
         hold_w <= '0;
         ovr    <= 1'b0;
      end else begin
         count <= count + CW'(push) - CW'(pop);
         if (hold_load) begin
            hold_v <= 1'b1;
            hold_w <= char_word;
         end else if (hold_clear) begin
            hold_v <= 1'b0;
         end
         if (ovr_set)      ovr <= 1'b1;
         else if (clr_err) ovr <= 1'b0;
      end
   end

   // R4
   hold_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v |-> (count == FULL_CNT));

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   // R5
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(hold_v && char_valid && !rd_stb));

   // R7
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr_err) |=> ovr);

   // R10
   no_ovr_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ovr) |=> !ovr);

   // R4
   full_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && rd_stb) |=> (count == FULL_CNT));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
   parameter int DW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_brk,
   input  logic          rx_fe,
   input  logic          rx_pe,
   input  logic          rd_stb,
   input  logic          clr_err,
   output logic [DW-1:0] rd_data,
   output logic          rd_brk,
   output logic          rd_fe,
   output logic          rd_pe,
   output logic          rx_ready,
   output logic          fifo_full,
   output logic          overrun
);

   import rcq_pkg::*;

   localparam int EW = DW + RCQ_STAT_W;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_queue: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("rx_char_queue: DW must be at least 1");
      end
   endgenerate

   rcq_stat_t     in_stat;
   logic [EW-1:0] in_word;
   logic          pop, push, hold_v;
   logic [EW-1:0] push_word, head_word, last_word, shown;
   logic [CW-1:0] count;

   assign in_stat = '{brk: rx_brk, fe: rx_fe, pe: rx_pe};
   assign in_word = {in_stat, rx_data};

   rcq_ctrl #(.DEPTH(DEPTH), .EW(EW), .CW(CW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_valid (rx_valid),
      .char_word  (in_word),
      .rd_stb     (rd_stb),
      .clr_err    (clr_err),
      .pop        (pop),
      .push       (push),
      .push_word  (push_word),
      .count      (count),
      .hold_v     (hold_v),
      .ovr        (overrun)
   );

   rcq_mem #(.DEPTH(DEPTH), .EW(EW)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (push),
      .wr_word   (push_word),
      .rd_en     (pop),
      .head_word (head_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_word <= '0;
      else if (pop) last_word <= head_word;
   end

   assign rx_ready  = (count != '0);
   assign fifo_full = (count == CW'(DEPTH));
   assign shown     = rx_ready ? head_word : last_word;

   rcq_stat_t shown_stat;
   assign shown_stat = rcq_stat_t'(shown[EW-1:DW]);
   assign rd_data    = shown[DW-1:0];
   assign rd_brk     = shown_stat.brk;
   assign rd_fe      = shown_stat.fe;
   assign rd_pe      = shown_stat.pe;

   // R9
   empty_read_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rx_ready && !rx_valid) |=> (!rx_ready && $stable(rd_data)));

   // R2
   ready_after_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !hold_v) |=> rx_ready);

endmodule

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;

   localparam int DW    = 8;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_brk = 1'b0, rx_fe = 1'b0, rx_pe = 1'b0;
   logic          rd_stb = 1'b0, clr_err = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_brk, rd_fe, rd_pe;
   logic          rx_ready, fifo_full, overrun;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rx_char_queue #(.DW(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_brk(rx_brk), .rx_fe(rx_fe), .rx_pe(rx_pe), .rd_stb(rd_stb),
      .clr_err(clr_err), .rd_data(rd_data), .rd_brk(rd_brk), .rd_fe(rd_fe),
      .rd_pe(rd_pe), .rx_ready(rx_ready), .fifo_full(fifo_full),
      .overrun(overrun)
   );

   // bench reference state: word = {from_hold, brk, fe, pe, data}
   logic [11:0] q[$];
   logic [11:0] hold_m = '0;
   logic        hold_vm = 1'b0;
   logic        ovr_m = 1'b0;
   logic [10:0] last_m = '0;
   string       ovr_tag = "R7";

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic cv, input logic [7:0] dat,
                       input logic [2:0] st, input logic rd, input logic clr);
      logic [10:0] exp_w;
      logic        popm, setm;
      string       dtag;
      @(negedge clk);
      rx_valid = cv; rx_data = dat; {rx_brk, rx_fe, rx_pe} = st;
      rd_stb = rd; clr_err = clr;
      #1;
      check("R2", "rx_ready", 32'(rx_ready), 32'(q.size() != 0));
      check(hold_vm ? "R4" : "R3", "fifo_full", 32'(fifo_full),
            32'(q.size() == DEPTH));
      check(ovr_tag, "overrun", 32'(overrun), 32'(ovr_m));
      if (q.size() == 0) begin
         exp_w = last_m; dtag = "R9";
      end else begin
         exp_w = q[0][10:0];
         dtag = q[0][11] ? "R6" : (rd ? "R8" : "R1");
      end
      check(dtag, "read word", 32'({rd_brk, rd_fe, rd_pe, rd_data}), 32'(exp_w));
      @(posedge clk);
      popm = rd && (q.size() != 0);
      setm = 1'b0;
      ovr_tag = ovr_m ? "R7" : "R5";
      if (popm) last_m = q.pop_front()[10:0];
      if (hold_vm) begin
         if (popm) begin
            q.push_back(hold_m);
            if (cv) begin hold_m = {1'b1, st, dat}; ovr_tag = "R10"; end
            else hold_vm = 1'b0;
         end else if (cv) begin
            hold_m = {1'b1, st, dat};
            setm = 1'b1;
         end
      end else if (cv) begin
         if (q.size() < DEPTH) begin
            q.push_back({1'b0, st, dat});
            if (popm && q.size() == DEPTH) ovr_tag = "R10";
         end else begin
            hold_m = {1'b1, st, dat};
            hold_vm = 1'b1;
         end
      end
      if (setm) ovr_m = 1'b1;
      else if (clr) ovr_m = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] lfsr;
      logic [7:0]  seq;
      int cv_th[6] = '{16, 12, 8, 4, 10, 16};
      int rd_th[6] = '{0, 4, 8, 12, 10, 16};
      lfsr = 16'hACE1;
      seq  = 8'h01;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      check("R11", "rx_ready", 32'(rx_ready), 0);
      check("R11", "fifo_full", 32'(fifo_full), 0);
      check("R11", "overrun", 32'(overrun), 0);
      check("R11", "read word", 32'({rd_brk, rd_fe, rd_pe, rd_data}), 0);
      rst_n = 1'b1;
      // empty read right after reset (R9)
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
      // fill past full, into hold, then overrun twice (R3 R4 R5 R6)
      for (int i = 0; i < DEPTH + 3; i++) begin
         step(1'b1, seq, seq[2:0] ^ seq[5:3], 1'b0, 1'b0);
         seq++;
      end
      // clear with no new event, then drain fully (R7 R4 R9)
      step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
      for (int i = 0; i < DEPTH + 3; i++)
         step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
      // sweep of arrival/read/clear densities over all fill levels
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < 500; c++) begin
            logic cv, rd, clr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cv  = int'(lfsr[3:0]) < cv_th[p];
            rd  = int'(lfsr[7:4]) < rd_th[p];
            clr = (lfsr[11:8] == 4'h0);
            step(cv, seq, seq[2:0] ^ seq[5:3], rd, clr);
            if (cv) seq++;
         end
         for (int i = 0; i < DEPTH + 2; i++)
            step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1);
      end
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule